// File: doc/BRIEF.md
# SPI Flash Command Guard

This block is the command front end of a serial flash device. It sits on the SPI slave pins and decodes one instruction per chip-select frame. It keeps the device status byte, which holds a write-enable latch, three block-protect bits and a lock bit for the status byte. It decides whether each program, erase or status-write instruction may proceed. An accepted instruction produces a one-cycle strobe together with its captured 24-bit address, and the array controller behind this block acts on that strobe. The block also serves the status byte back to the host over MISO.

The SPI pins are oversampled by a faster system clock through two-stage synchronisers, so all state lives in the system clock domain. SPI mode 0 is used: MOSI is taken on SCK rising edges and MISO changes after SCK falling edges. The block does no work of its own in the array. An external `busy` input reports that such work is in progress, and while it is high the guard ignores every instruction except the status read.

Top module: `spi_flash_guard`

## Requirements
- R1: A program (02h), sector erase (D8h) or status write (01h) frame is acted on only when the number of SCK rising edges between CS# falling and CS# rising is a non-zero multiple of eight. Any other such frame is dropped with no strobe and no change to the status byte, including the write-enable latch.
- R2: A program, erase or status write is refused unless the write-enable latch (status bit 1) is set. Only the 06h instruction sets the latch.
- R3: The latch is cleared by 04h, and by every complete, well-framed program, erase or status write, whether it is accepted or refused.
- R4: The block-protect field (status bits 4:2) guards 64 KB sectors, where the sector is address bits 18:16. Value 0 guards none, 1 guards sector 7, 2 guards sectors 6–7, 3 guards sectors 4–7, and 4 or more guards every sector. Program and sector erase into a guarded sector are refused. Bulk erase (C7h) is refused whenever the field is non-zero.
- R5: A status write (its first data byte supplies bit 7 as the lock bit and bits 4:2 as block protect) is refused while the lock bit is set and `wp_n` is low. The status byte then stays unchanged.
- R6: After B9h every instruction is ignored, including status reads, which return zeros. The only exception is ABh, which restores normal operation.
- R7: For HOLD_CYCLES clock cycles after `por_n` is released, every program, erase and status write is refused.
- R8: While `busy` is high, every instruction other than the status read (05h) is ignored, and status bit 0 reads as 1.
- R9: The status read shifts out {lock, 0, 0, bp[2:0], latch, busy} MSB first, changing MISO after SCK falls. It repeats the byte for as long as CS# stays low.
- R10: An accepted instruction raises exactly one of `prog_stb`, `sect_erase_stb`, `bulk_erase_stb` or `stat_wr_stb` for a single cycle. For program and sector erase, `cmd_addr` carries the three address bytes, first byte most significant.
- R11: While `por_n` is low, all strobes and MISO are low and the status byte is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sck | input | 1 | SPI clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in |
| miso | output | 1 | SPI data out (status read) |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Array operation in progress |
| prog_stb | output | 1 | Program accepted |
| sect_erase_stb | output | 1 | Sector erase accepted |
| bulk_erase_stb | output | 1 | Bulk erase accepted |
| stat_wr_stb | output | 1 | Status write accepted |
| cmd_addr | output | 24 | Captured address of the last frame |

## Verification
The bench builds the guard with HOLD_CYCLES of 1500. This is long enough that a write-enable and a full program frame both finish inside the hold-off window, so the refusal caused only by the timer can be seen. It is also short enough that the remaining tests run after the window closes. ADDR_BYTES stays at 3 and SECT_BITS at 3. The eight-sector map is therefore covered in full, including the setting where every sector is guarded. SCK runs at one twelfth of the system clock, which gives the synchronisers and the MISO register time to settle before each sampling point.

// File: rtl/spi_flash_guard.sv
module spi_flash_guard #(
  parameter int ADDR_BYTES  = 3,
  parameter int SECT_SHIFT  = 16,
  parameter int SECT_BITS   = 3,
  parameter int HOLD_CYCLES = 2500
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  sck,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  input  logic                  wp_n,
  input  logic                  busy,
  output logic                  prog_stb,
  output logic                  sect_erase_stb,
  output logic                  bulk_erase_stb,
  output logic                  stat_wr_stb,
  output logic [8*ADDR_BYTES-1:0] cmd_addr
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int HW     = $clog2(HOLD_CYCLES + 1);
  localparam logic [SECT_BITS:0] NSECT = (SECT_BITS+1)'(1) << SECT_BITS;
  localparam logic [2:0] ADDR_LEN = 3'(1 + ADDR_BYTES);

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [7:0] shreg, opcode, out_sr;
  logic [2:0] bitcnt, nbytes, bp, new_bp;
  logic       new_lock, wel, srwd, dpd;
  logic [HW-1:0] hold_cnt;
  logic [SECT_BITS:0] pcount;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sel      = ~cs_q[1];
  wire [7:0] next_sh = {shreg[6:0], mosi_q[1]};
  wire [7:0] status  = {srwd, 2'b00, bp, wel, busy};
  wire ready   = hold_cnt == HW'(HOLD_CYCLES);
  wire framed  = (bitcnt == 3'd0) && (nbytes != 3'd0);
  wire may_mod = wel && ready;
  wire [SECT_BITS-1:0] sect = cmd_addr[SECT_SHIFT +: SECT_BITS];
  wire sect_prot = {1'b0, sect} >= (NSECT - pcount);
  wire sr_lock   = srwd && !wp_n;

  assign miso = out_sr[7];

  always_comb begin
    if (bp == 3'd0)                pcount = '0;
    else if (int'(bp) > SECT_BITS) pcount = NSECT;
    else                           pcount = (SECT_BITS+1)'(1) << (bp - 3'd1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0; hold_cnt <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
      if (!ready) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      shreg <= '0; bitcnt <= '0; nbytes <= '0; opcode <= '0;
      cmd_addr <= '0; new_bp <= '0; new_lock <= 1'b0;
    end else if (cs_fall) begin
      shreg <= '0; bitcnt <= '0; nbytes <= '0; opcode <= '0;
    end else if (sel && sck_rise) begin
      shreg  <= next_sh;
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) begin
        if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
        if (nbytes == 3'd0) opcode <= next_sh;
        if (nbytes == 3'd1) begin
          new_bp   <= next_sh[4:2];
          new_lock <= next_sh[7];
        end
        if (nbytes != 3'd0 && nbytes < ADDR_LEN)
          cmd_addr <= {cmd_addr[ADDR_W-9:0], next_sh};
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wel <= 1'b0; bp <= '0; srwd <= 1'b0; dpd <= 1'b0;
      prog_stb <= 1'b0; sect_erase_stb <= 1'b0;
      bulk_erase_stb <= 1'b0; stat_wr_stb <= 1'b0;
    end else begin
      prog_stb <= 1'b0; sect_erase_stb <= 1'b0;
      bulk_erase_stb <= 1'b0; stat_wr_stb <= 1'b0;
      if (cs_rise && framed) begin
        if (dpd) begin
          if (opcode == 8'hAB) dpd <= 1'b0;
        end else if (!busy) begin
          case (opcode)
            8'h06: wel <= 1'b1;
            8'h04: wel <= 1'b0;
            8'hB9: dpd <= 1'b1;
            8'h02: if (nbytes >= ADDR_LEN) begin
              wel <= 1'b0;
              prog_stb <= may_mod && !sect_prot;
            end
            8'hD8: if (nbytes >= ADDR_LEN) begin
              wel <= 1'b0;
              sect_erase_stb <= may_mod && !sect_prot;
            end
            8'hC7: begin
              wel <= 1'b0;
              bulk_erase_stb <= may_mod && (bp == 3'd0);
            end
            8'h01: if (nbytes >= 3'd2) begin
              wel <= 1'b0;
              if (may_mod && !sr_lock) begin
                stat_wr_stb <= 1'b1;
                bp   <= new_bp;
                srwd <= new_lock;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) out_sr <= '0;
    else if (!sel) out_sr <= '0;
    else if (sck_fall) begin
      if (opcode == 8'h05 && !dpd && bitcnt == 3'd0 && nbytes != 3'd0)
        out_sr <= status;
      else
        out_sr <= {out_sr[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_flash_guard_chk.sv
module spi_flash_guard_chk #(
  parameter int HOLD_CYCLES = 2500
) (
  input logic clk,
  input logic por_n,
  input logic wp_n,
  input logic prog_stb,
  input logic sect_erase_stb,
  input logic bulk_erase_stb,
  input logic stat_wr_stb,
  input logic wel,
  input logic srwd,
  input logic dpd
);
  wire any_stb = prog_stb | sect_erase_stb | bulk_erase_stb | stat_wr_stb;
  int unsigned since_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) since_rst <= 0;
    else if (since_rst < HOLD_CYCLES) since_rst <= since_rst + 1;
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({prog_stb, sect_erase_stb, bulk_erase_stb, stat_wr_stb}));

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
    any_stb |=> !any_stb);

  p_needs_latch_r2: assert property (@(posedge clk) disable iff (!por_n)
    any_stb |-> $past(wel));

  p_latch_cleared_r3: assert property (@(posedge clk) disable iff (!por_n)
    any_stb |-> !wel);

  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!por_n)
    stat_wr_stb |-> !$past(srwd && !wp_n));

  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
    dpd |-> !any_stb);

  p_holdoff_r7: assert property (@(posedge clk) disable iff (!por_n)
    (since_rst < HOLD_CYCLES) |-> !any_stb);
endmodule

bind spi_flash_guard spi_flash_guard_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .wp_n(wp_n),
  .prog_stb(prog_stb), .sect_erase_stb(sect_erase_stb),
  .bulk_erase_stb(bulk_erase_stb), .stat_wr_stb(stat_wr_stb),
  .wel(wel), .srwd(srwd), .dpd(dpd)
);

// File: tb/spi_flash_guard_tb.sv
module spi_flash_guard_tb;
  localparam int HOLD = 1500;
  localparam int HALF = 6;

  logic clk = 0, por_n = 0, sck = 0, cs_n = 1, mosi = 0, wp_n = 1, busy = 0;
  logic miso, prog_stb, sect_erase_stb, bulk_erase_stb, stat_wr_stb;
  logic [23:0] cmd_addr;

  always #4 clk = ~clk;

  spi_flash_guard #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .por_n(por_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .wp_n(wp_n), .busy(busy), .prog_stb(prog_stb), .sect_erase_stb(sect_erase_stb),
    .bulk_erase_stb(bulk_erase_stb), .stat_wr_stb(stat_wr_stb), .cmd_addr(cmd_addr));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int obs_n, obs_kind, exp_n, exp_kind;
  logic [23:0] obs_addr, exp_addr;
  logic [7:0] fb [0:4];
  bit m_wel = 0, m_srwd = 0, m_dpd = 0, m_ready = 0;
  logic [2:0] m_bp = 0;

  always @(negedge clk) begin
    cyc++;
    if (prog_stb | sect_erase_stb | bulk_erase_stb | stat_wr_stb) begin
      obs_n++;
      obs_kind = prog_stb ? 1 : sect_erase_stb ? 2 : bulk_erase_stb ? 3 : 4;
      obs_addr = cmd_addr;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    sck = 1;
    repeat (HALF) @(negedge clk);
    sck = 0;
  endtask

  function automatic bit guarded(input logic [2:0] bp, input logic [2:0] s);
    case (bp)
      3'd0: return 0;
      3'd1: return s == 3'd7;
      3'd2: return s >= 3'd6;
      3'd3: return s >= 3'd4;
      default: return 1;
    endcase
  endfunction

  task automatic model(input int n, input int extra);
    logic [23:0] a;
    bit ok;
    exp_n = 0; exp_kind = 0; exp_addr = 0;
    a = {fb[1], fb[2], fb[3]};
    ok = m_wel && m_ready;
    if (extra == 0 && n >= 1) begin
      if (m_dpd) begin
        if (fb[0] == 8'hAB) m_dpd = 0;
      end else if (!busy) begin
        case (fb[0])
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'hB9: m_dpd = 1;
          8'h02, 8'hD8: if (n >= 4) begin
            if (ok && !guarded(m_bp, a[18:16])) begin
              exp_n = 1; exp_kind = (fb[0] == 8'h02) ? 1 : 2; exp_addr = a;
            end
            m_wel = 0;
          end
          8'hC7: begin
            if (ok && m_bp == 0) begin exp_n = 1; exp_kind = 3; end
            m_wel = 0;
          end
          8'h01: if (n >= 2) begin
            if (ok && !(m_srwd && !wp_n)) begin
              exp_n = 1; exp_kind = 4; m_bp = fb[1][4:2]; m_srwd = fb[1][7];
            end
            m_wel = 0;
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic run(input string req, input int n, input int extra);
    logic r;
    obs_n = 0; obs_kind = 0; obs_addr = 0;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) xbit(fb[i][j], r);
    for (int k = 0; k < extra; k++) xbit(1'b0, r);
    repeat (HALF) @(negedge clk);
    model(n, extra);
    cs_n = 1;
    repeat (12) @(negedge clk);
    chk({req, " strobe count"}, obs_n, exp_n);
    if (exp_n == 1) chk({req, " strobe kind"}, obs_kind, exp_kind);
    if (exp_kind == 1 || exp_kind == 2) chk({req, " address"}, obs_addr, exp_addr);
  endtask

  task automatic op1(input string req, input logic [7:0] o);
    fb[0] = o; run(req, 1, 0);
  endtask

  task automatic op4(input string req, input logic [7:0] o, input logic [23:0] a, input int extra);
    fb[0] = o; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0]; fb[4] = 8'h5A;
    run(req, 5, extra);
  endtask

  task automatic wrsr(input string req, input logic [7:0] d, input int extra);
    fb[0] = 8'h01; fb[1] = d; run(req, 2, extra);
  endtask

  task automatic rdsr(input string req);
    logic r;
    logic [7:0] b0, b1, e;
    e = m_dpd ? 8'h00 : {m_srwd, 2'b00, m_bp, m_wel, busy};
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int j = 7; j >= 0; j--) xbit(8'h05 >> j, r);
    for (int j = 7; j >= 0; j--) begin xbit(1'b0, r); b0[j] = r; end
    for (int j = 7; j >= 0; j--) begin xbit(1'b0, r); b1[j] = r; end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
    chk({req, " status byte"}, b0, e);
    chk({req, " R9 repeated status"}, b1, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 strobes in reset", {prog_stb, sect_erase_stb, bulk_erase_stb, stat_wr_stb}, 0);
    chk("R11 miso in reset", miso, 0);
    por_n = 1;
    repeat (3) @(negedge clk);
    op1("R7 wren in holdoff", 8'h06);
    op4("R7 program in holdoff", 8'h02, 24'h012345, 0);
    rdsr("R7 R3 after holdoff refusal");
    while (cyc < HOLD + 50) @(negedge clk);
    m_ready = 1;
    op4("R2 program without latch", 8'h02, 24'h012345, 0);
    op1("R2 wren", 8'h06);
    rdsr("R2 R9 latch visible");
    op4("R10 program accepted", 8'h02, 24'h012345, 0);
    rdsr("R3 latch cleared after program");
    op1("R2 wren", 8'h06);
    op4("R1 program misframed", 8'h02, 24'h020000, 3);
    rdsr("R1 latch kept after misframe");
    wrsr("R1 status write misframed", 8'h08, 1);
    rdsr("R1 status unchanged");
    wrsr("R4 set bp=2", 8'h08, 0);
    rdsr("R4 bp readback");
    op1("R2 wren", 8'h06);
    op4("R4 erase guarded sector 6", 8'hD8, 24'h060000, 0);
    rdsr("R3 latch cleared after refusal");
    op1("R2 wren", 8'h06);
    op4("R4 erase open sector 5", 8'hD8, 24'h05ABCD, 0);
    op1("R2 wren", 8'h06);
    op1("R4 bulk erase with bp", 8'hC7);
    op1("R2 wren", 8'h06);
    wrsr("R4 set bp=4", 8'h10, 0);
    op1("R2 wren", 8'h06);
    op4("R4 program sector 0 all guarded", 8'h02, 24'h000100, 0);
    op1("R2 wren", 8'h06);
    wrsr("R5 lock with wp_n high", 8'h8C, 0);
    rdsr("R5 lock readback");
    wp_n = 0;
    op1("R2 wren", 8'h06);
    wrsr("R5 write under hardware lock", 8'h00, 0);
    rdsr("R5 status kept");
    wp_n = 1;
    op1("R2 wren", 8'h06);
    wrsr("R5 write after wp_n released", 8'h00, 0);
    rdsr("R5 status cleared");
    op1("R2 wren", 8'h06);
    op1("R3 wrdi", 8'h04);
    rdsr("R3 latch cleared by wrdi");
    op1("R2 wren", 8'h06);
    op1("R4 bulk erase open", 8'hC7);
    op1("R6 deep power-down", 8'hB9);
    op1("R6 wren ignored", 8'h06);
    rdsr("R6 status read ignored");
    op1("R6 release", 8'hAB);
    rdsr("R6 after release");
    op1("R2 wren", 8'h06);
    busy = 1;
    op1("R8 wrdi ignored while busy", 8'h04);
    rdsr("R8 busy status");
    op4("R8 program ignored while busy", 8'h02, 24'h010000, 0);
    busy = 0;
    rdsr("R8 latch kept after busy");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule